// File: doc/BRIEF.md
# Security Block Filter

The filter sits on the path from one upstream bus master to one downstream memory and decides, for every transaction, whether it may pass. Memory is split into equal power-of-two blocks. Each block owns one configuration bit held in a table of 32-bit words: a set bit makes the block reachable only by non-secure transactions, and a clear bit makes it reachable only by secure ones. The check is combinational on the incoming address. A transaction that passes goes downstream in the same cycle. A transaction that fails never reaches the memory. It is completed locally and raises an interrupt status.

Software programs the table through a small register interface. It selects a table word with an index register and moves data through a data register. The index can advance by itself after each full-word table write. The first blocked access after the status was clear records its address and its security attribute.

The upstream and downstream transaction paths use valid/ready. The upstream side holds `up_valid` and all request fields stable until `up_ready` is high. A transfer happens in the cycle where both are high, and `up_rdata`/`up_err` are valid in that cycle. For an allowed transaction, `up_ready` follows `dn_ready`, so downstream back-pressure reaches the master unchanged. The downstream side must return `dn_rdata` in the cycle it asserts `dn_ready`. A blocked transaction never waits: `up_ready` is high and the transfer completes at once.

Top module: `secblk_filter`

## Requirements
- R1: The block number is the request address shifted right by log2(BLK_BYTES). Its value divided by 32 selects the table word, and its value modulo 32 selects the bit inside that word.
- R2: With the selected bit at 1, only requests with `up_nonsec`=1 are allowed. With the bit at 0, only requests with `up_nonsec`=0 are allowed.
- R3: An allowed request is forwarded in the same cycle: `dn_valid`=`up_valid`, the address, write flag and write data pass through, `up_ready`=`dn_ready`, `up_rdata`=`dn_rdata` and `up_err`=0.
- R4: A blocked request keeps `dn_valid` at 0 and sees `up_ready`=1 and `up_rdata`=0. `up_err` is 1 unless CTRL bit 1 (silent mode) is set, in which case it is 0. A blocked write therefore changes nothing downstream.
- R5: A write to INDEX (offset 0x04) stores the written value modulo NUM_WORDS. INDEX reads back the stored value.
- R6: A write to TABLE (offset 0x08) replaces the word selected by INDEX. A read of TABLE returns that word.
- R7: When CTRL bit 0 (auto-advance) is set and the TABLE write has `reg_full`=1, INDEX advances by one after the write and wraps from NUM_WORDS-1 to 0. Partial writes, and writes with the bit clear, leave INDEX unchanged.
- R8: After reset all table words, CTRL (0x00), INDEX, STAT (0x0C), INTEN (0x14), FADDR (0x18) and FINFO (0x1C) read 0, so every block is secure-only.
- R9: A blocked request that is accepted sets STAT bit 0. If STAT was clear before that edge, FADDR takes the request address and FINFO bit 0 takes `up_nonsec`. Later faults leave FADDR and FINFO alone while STAT stays set.
- R10: Writing 1 to bit 0 of CLEAR (0x10) clears STAT. If a fault is accepted in the same cycle, STAT stays set.
- R11: `irq` is 1 exactly when STAT bit 0 and INTEN bit 0 are both 1.
- R12: An address whose block number lies beyond the last table word is blocked for both secure and non-secure requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access in this cycle |
| reg_we | input | 1 | 1 write, 0 read |
| reg_full | input | 1 | Access is a full 32-bit word |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted |
| up_write | input | 1 | Request is a write |
| up_nonsec | input | 1 | Request is non-secure |
| up_addr | input | ADDR_W | Request byte address |
| up_wdata | input | 32 | Request write data |
| up_rdata | output | 32 | Read data returned to master |
| up_err | output | 1 | Error response |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accepts and responds |
| dn_write | output | 1 | Downstream write flag |
| dn_addr | output | ADDR_W | Downstream address |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data |
| irq | output | 1 | Interrupt |

## Verification
The assertions assume that a register access and a table write never target two offsets at once. They also assume that an upstream request counts as accepted only at a clock edge where `up_valid` is high. The bench drives every request and register access just after a falling edge and samples the combinational responses shortly after. Where a request must not be accepted, it drops `up_valid` again before the next rising edge, so a probe of a blocked address leaves the interrupt status alone. Only the fault scenarios hold `up_valid` across a rising edge.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  localparam int REG_AW = 6;

  localparam logic [REG_AW-1:0] OFS_CTRL  = 6'h00;
  localparam logic [REG_AW-1:0] OFS_INDEX = 6'h04;
  localparam logic [REG_AW-1:0] OFS_TABLE = 6'h08;
  localparam logic [REG_AW-1:0] OFS_STAT  = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_CLEAR = 6'h10;
  localparam logic [REG_AW-1:0] OFS_INTEN = 6'h14;
  localparam logic [REG_AW-1:0] OFS_FADDR = 6'h18;
  localparam logic [REG_AW-1:0] OFS_FINFO = 6'h1C;

  typedef struct packed {
    logic silent;    // bit 1: blocked accesses complete without error
    logic auto_adv;  // bit 0: index advances after full-word table writes
  } ctrl_t;
endpackage

// File: rtl/sbf_check.sv
module sbf_check #(
  parameter int ADDR_W    = 13,
  parameter int BLK_BYTES = 32,
  parameter int NUM_WORDS = 4
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    nonsec,
  input  logic [NUM_WORDS*32-1:0] table_flat,
  output logic                    allow,
  output logic                    in_range
);
  localparam int OFS_W = $clog2(BLK_BYTES);
  localparam int BLK_W = ADDR_W - OFS_W;

  logic [BLK_W-1:0] blk_num;
  logic [BLK_W-1:0] word_num;
  logic [4:0]       bit_sel;
  logic             cfg_bit;

  assign blk_num  = addr[ADDR_W-1:OFS_W];
  assign word_num = blk_num >> 5;
  assign bit_sel  = blk_num[4:0];

  always_comb begin
    in_range = 1'b0;
    cfg_bit  = 1'b0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (word_num == BLK_W'(w)) begin
        in_range = 1'b1;
        cfg_bit  = table_flat[w*32 + int'(bit_sel)];
      end
    end
  end

  // a set bit opens the block to non-secure traffic only
  assign allow = in_range && (cfg_bit == nonsec);
endmodule

// File: rtl/sbf_regs.sv
module sbf_regs
  import sbf_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int ADDR_W    = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_sel,
  input  logic                    reg_we,
  input  logic                    reg_full,
  input  logic [REG_AW-1:0]       reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic                    fault_evt,
  input  logic [ADDR_W-1:0]       fault_addr,
  input  logic                    fault_ns,
  output logic [NUM_WORDS*32-1:0] table_flat,
  output ctrl_t                   ctrl,
  output logic                    irq
);
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_WORDS - 1);

  logic [IDX_W-1:0]  idx;
  ctrl_t             ctrl_q;
  logic              int_stat, int_en, fns_q;
  logic [ADDR_W-1:0] faddr_q;
  logic [31:0]       words [NUM_WORDS];
  logic [31:0]       idx_mod;

  logic wr, wr_ctrl, wr_index, wr_table, wr_clear, wr_inten, step;

  assign wr       = reg_sel && reg_we;
  assign wr_ctrl  = wr && (reg_addr == OFS_CTRL);
  assign wr_index = wr && (reg_addr == OFS_INDEX);
  assign wr_table = wr && (reg_addr == OFS_TABLE);
  assign wr_clear = wr && (reg_addr == OFS_CLEAR) && reg_wdata[0];
  assign wr_inten = wr && (reg_addr == OFS_INTEN);
  assign step     = ctrl_q.auto_adv && reg_full;
  assign idx_mod  = reg_wdata % 32'(NUM_WORDS);

  // control and index
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      idx    <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[1:0]);
      if (wr_index)
        idx <= idx_mod[IDX_W-1:0];
      else if (wr_table && step)
        idx <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
    end
  end

  // lookup table storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WORDS; w++) words[w] <= '0;
    end else if (wr_table) begin
      words[idx] <= reg_wdata;
    end
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_flat
    assign table_flat[g*32 +: 32] = words[g];
  end

  // interrupt status, enable and fault capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_stat <= 1'b0;
      int_en   <= 1'b0;
      faddr_q  <= '0;
      fns_q    <= 1'b0;
    end else begin
      if (wr_inten) int_en <= reg_wdata[0];
      if (fault_evt) begin
        int_stat <= 1'b1;
        if (!int_stat) begin
          faddr_q <= fault_addr;
          fns_q   <= fault_ns;
        end
      end else if (wr_clear) begin
        int_stat <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_CTRL:  reg_rdata = {30'd0, ctrl_q};
      OFS_INDEX: reg_rdata = 32'(idx);
      OFS_TABLE: reg_rdata = words[idx];
      OFS_STAT:  reg_rdata = {31'd0, int_stat};
      OFS_INTEN: reg_rdata = {31'd0, int_en};
      OFS_FADDR: reg_rdata = 32'(faddr_q);
      OFS_FINFO: reg_rdata = {31'd0, fns_q};
      default:   reg_rdata = 32'd0;
    endcase
  end

  assign ctrl = ctrl_q;
  assign irq  = int_stat && int_en;

  // R5: the index never points past the table
  a_r5_index_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    32'(idx) < NUM_WORDS);

  // R7: auto-advance on a full-word table write, wrapping at the end
  a_r7_auto_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_table && ctrl_q.auto_adv && reg_full) |=>
      (idx == (($past(idx) == IDX_LAST) ? '0 : $past(idx) + 1'b1)));

  // R9: status only rises after an accepted fault
  a_r9_status_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_stat) |-> $past(fault_evt));

  // R10: a clear with no competing fault empties the status
  a_r10_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clear && !fault_evt) |=> !int_stat);
endmodule

// File: rtl/sbf_route.sv
module sbf_route #(
  parameter int ADDR_W = 13
) (
  input  logic              up_valid,
  output logic              up_ready,
  input  logic              up_write,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [31:0]       up_wdata,
  output logic [31:0]       up_rdata,
  output logic              up_err,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_write,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [31:0]       dn_wdata,
  input  logic [31:0]       dn_rdata,
  input  logic              allow,
  input  logic              silent,
  output logic              fault_evt
);
  assign dn_write = up_write;
  assign dn_addr  = up_addr;
  assign dn_wdata = up_wdata;

  always_comb begin
    if (allow) begin
      dn_valid = up_valid;
      up_ready = dn_ready;
      up_rdata = dn_rdata;
      up_err   = 1'b0;
    end else begin
      dn_valid = 1'b0;
      up_ready = 1'b1;
      up_rdata = 32'd0;
      up_err   = up_valid && !silent;
    end
  end

  // blocked requests are always accepted at once
  assign fault_evt = up_valid && !allow;
endmodule

// File: rtl/secblk_filter.sv
module secblk_filter
  import sbf_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BLK_BYTES = 32,
  parameter int NUM_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic              reg_full,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic              up_write,
  input  logic              up_nonsec,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [31:0]       up_wdata,
  output logic [31:0]       up_rdata,
  output logic              up_err,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_write,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [31:0]       dn_wdata,
  input  logic [31:0]       dn_rdata,
  output logic              irq
);
  logic [NUM_WORDS*32-1:0] table_flat;
  ctrl_t                   ctrl;
  logic                    allow, in_range, fault_evt;

  sbf_regs #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .reg_sel, .reg_we, .reg_full, .reg_addr, .reg_wdata,
    .reg_rdata,
    .fault_evt (fault_evt),
    .fault_addr(up_addr),
    .fault_ns  (up_nonsec),
    .table_flat(table_flat),
    .ctrl      (ctrl),
    .irq       (irq)
  );

  sbf_check #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .NUM_WORDS(NUM_WORDS)) u_check (
    .addr      (up_addr),
    .nonsec    (up_nonsec),
    .table_flat(table_flat),
    .allow     (allow),
    .in_range  (in_range)
  );

  sbf_route #(.ADDR_W(ADDR_W)) u_route (
    .up_valid, .up_ready, .up_write, .up_addr, .up_wdata, .up_rdata, .up_err,
    .dn_valid, .dn_ready, .dn_write, .dn_addr, .dn_wdata, .dn_rdata,
    .allow     (allow),
    .silent    (ctrl.silent),
    .fault_evt (fault_evt)
  );

  // R3: an allowed request reaches memory and returns its data cleanly
  a_r3_allowed_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && allow) |-> (dn_valid && !up_err && up_rdata == dn_rdata));

  // R4: a blocked request never reaches memory and returns zero at once
  a_r4_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !allow) |-> (!dn_valid && up_ready && up_rdata == 32'd0));

  // R12: addresses beyond the table never pass
  a_r12_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !in_range) |-> !dn_valid);
endmodule

// File: tb/secblk_filter_test.sv
module secblk_filter_test;
  localparam int PERIOD = 10;
  localparam int ADDR_W = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_sel = 0, reg_we = 0, reg_full = 0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic up_valid = 0, up_ready, up_write = 0, up_nonsec = 0;
  logic [ADDR_W-1:0] up_addr = '0;
  logic [31:0] up_wdata = '0, up_rdata;
  logic up_err, dn_valid, dn_ready = 1, dn_write;
  logic [ADDR_W-1:0] dn_addr;
  logic [31:0] dn_wdata, dn_rdata = 32'hA5A5_1234;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 0;

  secblk_filter uut (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [31:0] d, input logic full = 1'b1);
    @(negedge clk);
    reg_sel = 1; reg_we = 1; reg_addr = a; reg_wdata = d; reg_full = full;
    @(posedge clk); #1;
    reg_sel = 0; reg_we = 0;
  endtask

  task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1; reg_we = 0; reg_addr = a;
    #1 d = reg_rdata;
    reg_sel = 0;
  endtask

  // combinational probe, withdrawn before the next rising edge
  task automatic probe(input logic [ADDR_W-1:0] a, input logic ns, input logic wr,
                       output logic dv, output logic rdy, output logic [31:0] rd,
                       output logic er);
    @(negedge clk);
    up_valid = 1; up_addr = a; up_nonsec = ns; up_write = wr; up_wdata = 32'h0BAD_F00D;
    #1 dv = dn_valid; rdy = up_ready; rd = up_rdata; er = up_err;
    up_valid = 0;
  endtask

  // request held across a rising edge so it is accepted
  task automatic accept(input logic [ADDR_W-1:0] a, input logic ns, input logic also_clear);
    @(negedge clk);
    up_valid = 1; up_addr = a; up_nonsec = ns; up_write = 1;
    if (also_clear) begin
      reg_sel = 1; reg_we = 1; reg_addr = 6'h10; reg_wdata = 32'd1; reg_full = 1;
    end
    @(posedge clk); #1;
    up_valid = 0; reg_sel = 0; reg_we = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    reg_rd(6'h00, v); chk("R8 ctrl", v, 0);
    reg_rd(6'h04, v); chk("R8 index", v, 0);
    reg_rd(6'h08, v); chk("R8 table", v, 0);
    reg_rd(6'h0C, v); chk("R8 stat", v, 0);
    reg_rd(6'h14, v); chk("R8 inten", v, 0);
    reg_rd(6'h18, v); chk("R8 faddr", v, 0);
    reg_rd(6'h1C, v); chk("R8 finfo", v, 0);
    chk("R8 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_mapping;
    logic dv, rdy, er; logic [31:0] rd, v;
    probe(13'h000, 0, 0, dv, rdy, rd, er); chk("R8 secure passes at reset", {31'd0, dv}, 1);
    probe(13'h000, 1, 0, dv, rdy, rd, er); chk("R2 nonsec blocked at reset", {31'd0, dv}, 0);
    reg_wr(6'h04, 32'd1);
    reg_wr(6'h08, 32'h0000_0004);
    reg_rd(6'h08, v); chk("R6 table readback", v, 32'h4);
    // word 1 bit 2 -> block 34 -> 0x440
    probe(13'h440, 1, 0, dv, rdy, rd, er); chk("R1 R2 nonsec to block 34", {31'd0, dv}, 1);
    probe(13'h440, 0, 0, dv, rdy, rd, er); chk("R2 secure to block 34", {31'd0, dv}, 0);
    probe(13'h45C, 1, 0, dv, rdy, rd, er); chk("R1 last byte of block 34", {31'd0, dv}, 1);
    probe(13'h460, 0, 0, dv, rdy, rd, er); chk("R1 secure to block 35", {31'd0, dv}, 1);
    probe(13'h460, 1, 0, dv, rdy, rd, er); chk("R1 nonsec to block 35", {31'd0, dv}, 0);
  endtask

  task automatic t_forward;
    logic dv, rdy, er; logic [31:0] rd;
    dn_ready = 0;
    probe(13'h100, 0, 1, dv, rdy, rd, er);
    chk("R3 stall valid", {31'd0, dv}, 1);
    chk("R3 stall ready", {31'd0, rdy}, 0);
    dn_ready = 1; dn_rdata = 32'h1357_9BDF;
    @(negedge clk);
    up_valid = 1; up_addr = 13'h100; up_nonsec = 0; up_write = 1; up_wdata = 32'hCAFE_0001;
    #1;
    chk("R3 addr", 32'(dn_addr), 32'h100);
    chk("R3 wdata", dn_wdata, 32'hCAFE_0001);
    chk("R3 write flag", {31'd0, dn_write}, 1);
    chk("R3 rdata", up_rdata, 32'h1357_9BDF);
    chk("R3 ready", {31'd0, up_ready}, 1);
    chk("R3 err", {31'd0, up_err}, 0);
    up_valid = 0;
  endtask

  task automatic t_blocked;
    logic dv, rdy, er; logic [31:0] rd;
    dn_ready = 0;
    probe(13'h080, 1, 0, dv, rdy, rd, er);
    chk("R4 no downstream", {31'd0, dv}, 0);
    chk("R4 ready despite stall", {31'd0, rdy}, 1);
    chk("R4 rdata zero", rd, 0);
    chk("R4 err", {31'd0, er}, 1);
    probe(13'h080, 1, 1, dv, rdy, rd, er);
    chk("R4 blocked write ignored", {31'd0, dv}, 0);
    reg_wr(6'h00, 32'h2);
    probe(13'h080, 1, 0, dv, rdy, rd, er);
    chk("R4 silent err", {31'd0, er}, 0);
    chk("R4 silent rdata", rd, 0);
    reg_wr(6'h00, 32'h0);
    dn_ready = 1;
  endtask

  task automatic t_modulo;
    logic [31:0] v;
    reg_wr(6'h04, 32'd6); reg_rd(6'h04, v); chk("R5 6 mod 4", v, 2);
    reg_wr(6'h04, 32'd4); reg_rd(6'h04, v); chk("R5 4 mod 4", v, 0);
    reg_wr(6'h04, 32'd3); reg_rd(6'h04, v); chk("R5 3 kept", v, 3);
  endtask

  task automatic t_autoinc;
    logic [31:0] v;
    reg_wr(6'h04, 32'd3);
    reg_wr(6'h08, 32'hDEAD_0000);
    reg_rd(6'h04, v); chk("R7 no advance when off", v, 3);
    reg_rd(6'h08, v); chk("R6 word 3", v, 32'hDEAD_0000);
    reg_wr(6'h00, 32'h1);
    reg_wr(6'h08, 32'hBEEF_0003);
    reg_rd(6'h04, v); chk("R7 wrap to 0", v, 0);
    reg_wr(6'h08, 32'h0, 1'b0);
    reg_rd(6'h04, v); chk("R7 partial no advance", v, 0);
    reg_wr(6'h08, 32'h0);
    reg_rd(6'h04, v); chk("R7 advance to 1", v, 1);
    reg_rd(6'h08, v); chk("R7 word 1 untouched", v, 32'h4);
    reg_wr(6'h04, 32'd3);
    reg_rd(6'h08, v); chk("R6 word 3 rewritten", v, 32'hBEEF_0003);
    reg_wr(6'h00, 32'h0);
  endtask

  task automatic t_fault;
    logic [31:0] v;
    accept(13'h020, 1, 0);
    reg_rd(6'h0C, v); chk("R9 status set", v, 1);
    reg_rd(6'h18, v); chk("R9 fault addr", v, 32'h020);
    reg_rd(6'h1C, v); chk("R9 fault nonsec", v, 1);
    chk("R11 irq masked", {31'd0, irq}, 0);
    accept(13'h440, 0, 0);
    reg_rd(6'h18, v); chk("R9 second fault keeps addr", v, 32'h020);
    reg_rd(6'h1C, v); chk("R9 second fault keeps info", v, 1);
    reg_wr(6'h14, 32'd1);
    #1 chk("R11 irq on", {31'd0, irq}, 1);
    reg_wr(6'h10, 32'd1);
    #1 chk("R10 cleared irq", {31'd0, irq}, 0);
    reg_rd(6'h0C, v); chk("R10 status cleared", v, 0);
    accept(13'h440, 0, 1);
    reg_rd(6'h0C, v); chk("R10 fault wins over clear", v, 1);
    reg_rd(6'h18, v); chk("R9 new capture", v, 32'h440);
    reg_rd(6'h1C, v); chk("R9 new capture secure", v, 0);
    reg_wr(6'h10, 32'd1);
  endtask

  task automatic t_range;
    logic dv, rdy, er; logic [31:0] rd;
    probe(13'h1000, 0, 0, dv, rdy, rd, er); chk("R12 secure beyond table", {31'd0, dv}, 0);
    probe(13'h1FE0, 1, 0, dv, rdy, rd, er); chk("R12 nonsec beyond table", {31'd0, dv}, 0);
    chk("R12 error reported", {31'd0, er}, 1);
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_mapping();
    t_forward();
    t_blocked();
    t_modulo();
    t_autoinc();
    t_fault();
    t_range();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule